// File: doc/BRIEF.md
# Serial Engine Run/Pause State Controller

This block holds the operating state of a serial bus engine and the status flags that engine raises, behind a small register write/read port. Software asks for one of three states (reset, run, pause) by writing the state register. Every accepted request takes a fixed settling time, and a valid bit in the same register reads 0 until that time has passed. Software therefore polls for valid before it writes a new state and polls again afterwards. A separate software-reset register forces the state back to reset from any situation, even while a change is still settling.

The engine itself is not part of the block. It appears only as event pulses, which set sticky flags in an operational register, and as level inputs, which that register shows directly. Software clears the sticky flags by writing ones to them. A master-generation register enables tagged operation, and its effect is reported as a master-ready bit in the state register. The settling time is a number of interface clocks plus a number of engine clocks. The engine clock is modelled as a fixed divide of the one block clock, so all logic is synchronous.

Top module: `bus_state_ctrl`

## Requirements
- R1: After reset the state is reset (0), valid reads 1, the master-ready bit is 0 and every operational flag is 0.
- R2: The register map is address 0 state, 1 software reset, 2 master generation and 3 operational. In the state register, bits 1:0 hold the state (reset=0, run=1, pause=3), bit 2 holds valid and bit 4 holds master-ready. All other bits read 0.
- R3: A state write that is accepted drops valid in the next cycle and holds it low for exactly HOST_SYNC + ENG_SYNC*ENG_DIV cycles (15 with the defaults). During that time the old state is still reported. The requested state appears in the same cycle that valid returns to 1.
- R4: A state write made while valid is 0 is ignored. The settling in progress and its target are unchanged.
- R5: A state write of the value 2 is ignored. Valid stays 1 and the state is unchanged. The state field never holds 2.
- R6: Writing 1 in bit 0 of the software-reset register starts a full settling period toward reset, even in the middle of a transition. It also clears the operational sticky flags and the master-generation enable. Writing 0 there has no effect.
- R7: Bit 0 of the master-generation register is read back at address 2. From the cycle after it is written, the same value appears as master-ready in bit 4 of the state register.
- R8: In the operational register the sticky flags are NACK at bit 3, output-service at bit 8, input-service at bit 9, output-done at bit 10 and input-done at bit 11. A one-cycle event pulse sets the flag, and it stays set. Output-not-empty (bit 4), input-not-empty (bit 5) and output-full (bit 6) follow their level inputs directly.
- R9: Writing 1 to a sticky bit of the operational register clears it, and writing 0 leaves it unchanged. If an event and a clear hit the same flag in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address, used for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| ev_nack | input | 1 | Engine event: NACK seen |
| ev_out_svc | input | 1 | Engine event: output needs service |
| ev_in_svc | input | 1 | Engine event: input needs service |
| ev_out_done | input | 1 | Engine event: output count reached |
| ev_in_done | input | 1 | Engine event: input count reached |
| lv_out_not_empty | input | 1 | Engine level: output queue holds data |
| lv_in_not_empty | input | 1 | Engine level: input queue holds data |
| lv_out_full | input | 1 | Engine level: output queue full |
| cur_state | output | 2 | Currently reported state |
| state_valid | output | 1 | 1 when no transition is settling |

## Verification
The assertions check on every cycle that the state field never holds 2 and that the reported state changes only in the cycle valid rises. They also check that a write during settling leaves the target unchanged, that a software reset restarts settling toward reset with the flags cleared, and that events set flags while a clear without an event empties them. Only the bench scenarios can show the exact length of the low-valid window, because the assertions cannot count it for every parameter set. The bench sweeps every pair of starting state and requested value, and it also checks a software reset in the middle of a transition, the bit positions as software reads them, and the rule that a set wins over a clear in the same cycle.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_BAD   = 2'd2,
        ST_PAUSE = 2'd3
    } ctl_state_e;

    typedef enum logic [1:0] {
        A_STATE = 2'd0,
        A_SWRST = 2'd1,
        A_MGEN  = 2'd2,
        A_OPER  = 2'd3
    } reg_addr_e;

    // state register layout
    localparam int SB_VALID = 2;
    localparam int SB_MRDY  = 4;

    // operational register layout
    localparam int OB_NACK   = 3;
    localparam int OB_OUT_NE = 4;
    localparam int OB_IN_NE  = 5;
    localparam int OB_OUT_FL = 6;
    localparam int OB_O_SVC  = 8;
    localparam int OB_I_SVC  = 9;
    localparam int OB_O_DONE = 10;
    localparam int OB_I_DONE = 11;

    typedef struct packed {
        logic nack;
        logic out_svc;
        logic in_svc;
        logic out_done;
        logic in_done;
    } sticky_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOST = 2'd1,
        PH_ENG  = 2'd2
    } settle_ph_e;

    function automatic logic is_legal_target(input logic [1:0] v);
        return (v != ST_BAD);
    endfunction

    function automatic int settle_len(input int host_n, input int eng_n, input int div_n);
        return host_n + eng_n * div_n;
    endfunction

    function automatic sticky_t sticky_from_word(input logic [31:0] w);
        sticky_t s;
        s.nack     = w[OB_NACK];
        s.out_svc  = w[OB_O_SVC];
        s.in_svc   = w[OB_I_SVC];
        s.out_done = w[OB_O_DONE];
        s.in_done  = w[OB_I_DONE];
        return s;
    endfunction

endpackage

// File: rtl/bsc_settle.sv
module bsc_settle
    import bsc_pkg::*;
#(
    parameter int HOST_SYNC = 3,
    parameter int ENG_SYNC  = 3,
    parameter int ENG_DIV   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic fin
);
    localparam int CNT_MAX = (HOST_SYNC > ENG_SYNC) ? HOST_SYNC : ENG_SYNC;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int DW      = $clog2(ENG_DIV + 1);

    settle_ph_e    ph_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] div_q;

    assign busy = (ph_q != PH_IDLE);
    assign fin  = (ph_q == PH_ENG) && (div_q == '0) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            div_q <= '0;
        end else if (start) begin
            ph_q  <= PH_HOST;
            cnt_q <= CW'(HOST_SYNC - 1);
            div_q <= '0;
        end else begin
            unique case (ph_q)
                PH_HOST: begin
                    if (cnt_q == '0) begin
                        ph_q  <= PH_ENG;
                        cnt_q <= CW'(ENG_SYNC - 1);
                        div_q <= DW'(ENG_DIV - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_ENG: begin
                    if (div_q != '0) begin
                        div_q <= div_q - 1'b1;
                    end else if (cnt_q == '0) begin
                        ph_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                        div_q <= DW'(ENG_DIV - 1);
                    end
                end
                default: begin
                    ph_q <= PH_IDLE;
                end
            endcase
        end
    end

    // R3: a start always makes the block busy next cycle
    p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R3: finishing without a new start returns to idle
    p_fin_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (fin && !start) |=> !busy);

endmodule

// File: rtl/bsc_opflags.sv
module bsc_opflags
    import bsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr_all,
    input  sticky_t set_vec,
    input  sticky_t w1c_vec,
    output sticky_t flags
);
    sticky_t flags_q;

    always_ff @(posedge clk) begin
        if (rst || clr_all) flags_q <= '0;
        else                flags_q <= (flags_q & ~w1c_vec) | set_vec;
    end

    assign flags = flags_q;

    // R8: every event pulse leaves its flag set
    p_set_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !clr_all |=> ((flags & $past(set_vec)) == $past(set_vec)));

    // R9: a clear with no competing event empties the flag
    p_w1c_clears_r9: assert property (@(posedge clk) disable iff (rst)
        !clr_all |=> ((flags & $past(w1c_vec) & ~$past(set_vec)) == '0));

    // R6: software reset empties all sticky flags
    p_clr_all_r6: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (flags == '0));

endmodule

// File: rtl/bus_state_ctrl.sv
module bus_state_ctrl
    import bsc_pkg::*;
#(
    parameter int HOST_SYNC = 3,
    parameter int ENG_SYNC  = 3,
    parameter int ENG_DIV   = 4,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_nack,
    input  logic              ev_out_svc,
    input  logic              ev_in_svc,
    input  logic              ev_out_done,
    input  logic              ev_in_done,
    input  logic              lv_out_not_empty,
    input  logic              lv_in_not_empty,
    input  logic              lv_out_full,
    output logic [1:0]        cur_state,
    output logic              state_valid
);
    ctl_state_e state_q, tgt_q;
    logic       mg_q;
    logic       busy, fin;
    logic       wr_state, wr_sr, wr_mg, wr_op, accept;
    sticky_t    set_vec, w1c_vec, flags;

    assign wr_state = reg_wr && (reg_addr == A_STATE);
    assign wr_sr    = reg_wr && (reg_addr == A_SWRST) && reg_wdata[0];
    assign wr_mg    = reg_wr && (reg_addr == A_MGEN);
    assign wr_op    = reg_wr && (reg_addr == A_OPER);
    assign accept   = wr_sr || (wr_state && !busy && is_legal_target(reg_wdata[1:0]));

    bsc_settle #(
        .HOST_SYNC (HOST_SYNC),
        .ENG_SYNC  (ENG_SYNC),
        .ENG_DIV   (ENG_DIV)
    ) u_settle (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .busy  (busy),
        .fin   (fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RESET;
            tgt_q   <= ST_RESET;
        end else begin
            if (fin)
                state_q <= tgt_q;
            if (wr_sr)
                tgt_q <= ST_RESET;
            else if (accept)
                tgt_q <= ctl_state_e'(reg_wdata[1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || wr_sr) mg_q <= 1'b0;
        else if (wr_mg)   mg_q <= reg_wdata[0];
    end

    always_comb begin
        set_vec.nack     = ev_nack;
        set_vec.out_svc  = ev_out_svc;
        set_vec.in_svc   = ev_in_svc;
        set_vec.out_done = ev_out_done;
        set_vec.in_done  = ev_in_done;
        w1c_vec          = wr_op ? sticky_from_word(32'(reg_wdata)) : '0;
    end

    bsc_opflags u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr_all (wr_sr),
        .set_vec (set_vec),
        .w1c_vec (w1c_vec),
        .flags   (flags)
    );

    assign cur_state   = state_q;
    assign state_valid = !busy;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_STATE: begin
                reg_rdata[1:0]      = state_q;
                reg_rdata[SB_VALID] = !busy;
                reg_rdata[SB_MRDY]  = mg_q;
            end
            A_MGEN: reg_rdata[0] = mg_q;
            A_OPER: begin
                reg_rdata[OB_NACK]   = flags.nack;
                reg_rdata[OB_OUT_NE] = lv_out_not_empty;
                reg_rdata[OB_IN_NE]  = lv_in_not_empty;
                reg_rdata[OB_OUT_FL] = lv_out_full;
                reg_rdata[OB_O_SVC]  = flags.out_svc;
                reg_rdata[OB_I_SVC]  = flags.in_svc;
                reg_rdata[OB_O_DONE] = flags.out_done;
                reg_rdata[OB_I_DONE] = flags.in_done;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R5: the reported state is never the unused code
    p_no_bad_state_r5: assert property (@(posedge clk) disable iff (rst)
        state_q != ST_BAD);

    // R3: the reported state moves only when valid comes back
    p_state_moves_on_valid_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(state_q) |-> $rose(state_valid));

    // R4: a request while settling leaves the target alone
    p_busy_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && !fin && wr_state) |=> ($stable(tgt_q) && !state_valid));

    // R5: requesting code 2 while idle keeps valid high
    p_bad_req_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_state && reg_wdata[1:0] == 2'd2) |=> state_valid);

    // R6: software reset restarts settling toward reset
    p_swrst_r6: assert property (@(posedge clk) disable iff (rst)
        wr_sr |=> (!state_valid && tgt_q == ST_RESET && !mg_q));

    // R7: master-ready follows the last enable written
    p_mgen_r7: assert property (@(posedge clk) disable iff (rst)
        wr_mg |=> (mg_q == $past(reg_wdata[0])));

endmodule

// File: tb/sim_bus_state_ctrl.sv
module sim_bus_state_ctrl;
    localparam int HS = 3, ES = 3, DV = 4;
    localparam int SETTLE = HS + ES * DV;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic ev_nack = 0, ev_out_svc = 0, ev_in_svc = 0, ev_out_done = 0, ev_in_done = 0;
    logic lv_out_not_empty = 0, lv_in_not_empty = 0, lv_out_full = 0;
    logic [1:0] cur_state;
    logic       state_valid;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bus_state_ctrl #(.HOST_SYNC(HS), .ENG_SYNC(ES), .ENG_DIV(DV)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_nack(ev_nack), .ev_out_svc(ev_out_svc), .ev_in_svc(ev_in_svc),
        .ev_out_done(ev_out_done), .ev_in_done(ev_in_done),
        .lv_out_not_empty(lv_out_not_empty), .lv_in_not_empty(lv_in_not_empty),
        .lv_out_full(lv_out_full), .cur_state(cur_state), .state_valid(state_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // counts cycles with valid low, checking the old state is still shown
    task automatic count_low(input logic [1:0] old_s, output int n);
        n = 0;
        while (state_valid == 1'b0 && n < 200) begin
            if (cur_state !== old_s) check("R3 old state shown", 32'(cur_state), 32'(old_s));
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_valid();
        int k = 0;
        while (state_valid == 1'b0 && k < 200) begin k++; @(negedge clk); end
    endtask

    task automatic go_to(input logic [1:0] s);
        if (cur_state != s) begin
            wr(2'd0, 32'(s));
            wait_valid();
        end
    endtask

    function automatic logic [31:0] exp_state_word(input logic [1:0] s, input logic v, input logic m);
        return (32'(m) << 4) | (32'(v) << 2) | 32'(s);
    endfunction

    task automatic pulse_ev(input int which);
        @(negedge clk);
        case (which)
            0: ev_nack = 1; 1: ev_out_svc = 1; 2: ev_in_svc = 1;
            3: ev_out_done = 1; default: ev_in_done = 1;
        endcase
        @(negedge clk);
        ev_nack = 0; ev_out_svc = 0; ev_in_svc = 0; ev_out_done = 0; ev_in_done = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        int bitpos [5] = '{3, 8, 9, 10, 11};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); check("R1 state reg after reset", d, exp_state_word(2'd0, 1'b1, 1'b0));
        rd(2'd3, d); check("R1 flags after reset", d, 32'h0);
        rd(2'd2, d); check("R1 mgen after reset", d, 32'h0);
        rd(2'd1, d); check("R2 swrst reads zero", d, 32'h0);

        // R3/R5 sweep every start state against every requested code
        foreach (bitpos[i]) ; // keep array referenced
        for (int si = 0; si < 3; si++) begin
            logic [1:0] s;
            s = (si == 0) ? 2'd0 : (si == 1) ? 2'd1 : 2'd3;
            for (int t = 0; t < 4; t++) begin
                go_to(s);
                wr(2'd0, 32'(t));
                if (t == 2) begin
                    check("R5 code 2 keeps valid", 32'(state_valid), 32'h1);
                    check("R5 code 2 keeps state", 32'(cur_state), 32'(s));
                end else begin
                    count_low(s, n);
                    check("R3 settle length", 32'(n), 32'(SETTLE));
                    check("R3 new state", 32'(cur_state), 32'(t));
                    rd(2'd0, d);
                    check("R2 state word", d, exp_state_word(2'(t), 1'b1, 1'b0));
                end
            end
        end

        // R4 request while settling is ignored
        go_to(2'd0);
        wr(2'd0, 32'd1);
        @(negedge clk);
        wr(2'd0, 32'd3);
        check("R4 still settling", 32'(state_valid), 32'h0);
        wait_valid();
        check("R4 target kept", 32'(cur_state), 32'h1);

        // R6 software reset mid-transition restarts settling
        go_to(2'd1);
        wr(2'd0, 32'd3);
        repeat (4) @(negedge clk);
        wr(2'd1, 32'h1);
        count_low(2'd1, n);
        check("R6 full settle after swrst", 32'(n), 32'(SETTLE));
        check("R6 state reset", 32'(cur_state), 32'h0);
        wr(2'd1, 32'h0);
        check("R6 zero write no effect", 32'(state_valid), 32'h1);

        // R7 master generation
        wr(2'd2, 32'h1);
        rd(2'd0, d); check("R7 master ready shown", d, exp_state_word(2'd0, 1'b1, 1'b1));
        rd(2'd2, d); check("R7 mgen readback", d, 32'h1);

        // R8 sticky events and level bits
        for (int e = 0; e < 5; e++) begin
            pulse_ev(e);
            rd(2'd3, d); check("R8 event sets flag", d, 32'h1 << bitpos[e]);
            wr(2'd3, 32'h0);
            rd(2'd3, d); check("R9 zero write keeps", d, 32'h1 << bitpos[e]);
            wr(2'd3, 32'h1 << bitpos[e]);
            rd(2'd3, d); check("R9 w1c clears", d, 32'h0);
        end
        lv_out_not_empty = 1; rd(2'd3, d); check("R8 out not empty", d, 32'h10);
        lv_out_not_empty = 0; lv_in_not_empty = 1; rd(2'd3, d); check("R8 in not empty", d, 32'h20);
        lv_in_not_empty = 0; lv_out_full = 1; rd(2'd3, d); check("R8 out full", d, 32'h40);
        lv_out_full = 0;

        // R9 set wins over same-cycle clear
        @(negedge clk);
        reg_wr = 1; reg_addr = 2'd3; reg_wdata = 32'h100; ev_out_svc = 1;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0; ev_out_svc = 0;
        rd(2'd3, d); check("R9 set wins", d, 32'h100);

        // R6 software reset clears flags and master enable
        pulse_ev(4);
        wr(2'd1, 32'h1);
        rd(2'd3, d); check("R6 flags cleared", d, 32'h0);
        rd(2'd2, d); check("R6 mgen cleared", d, 32'h0);
        wait_valid();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule